// File: doc/BRIEF.md
# Dual-Output Interrupt Controller with Idle Wake

This block collects a set of interrupt source lines and presents them to a processor through a small bank of 32-bit registers on a plain read/write bus. Each source can be enabled or disabled, captured either as a level or as a latched rising edge, and routed to one of two request outputs: the normal interrupt line (`irq_o`) or the fast interrupt line (`fiq_o`). Software reads the enabled-and-active view of the sources from a read-only pending register. The same register also clears latched edges when written with ones.

A separate wake path serves a processor that has entered idle mode. One control bit chooses the qualifying condition for a wake request. With the bit set, only enabled sources can wake the processor. With it clear, any active source can, including a masked one. The wake request comes from a three-state machine:

- `ST_RUN`: the processor is not idle.
- `ST_SLEEP`: idle, with no wake request yet.
- `ST_WAKE`: a wake request is being held.

The transitions are:

- `RUN→SLEEP` when idle is seen.
- `SLEEP→RUN` when idle drops.
- `SLEEP→WAKE` when idle is seen and a qualifying source is active.
- `WAKE→RUN` when idle drops.

In every other case the state holds.

Top module: `ic_irq_fiq_ctl`

## Requirements
- R1: After reset, every register reads zero, no edge is latched, and `irq_o`, `fiq_o` and `wake_o` are low.
- R2: Word index 0 is the enable register. It is read/write, and bit i set to 1 enables source i.
- R3: Word index 1 is the read-only pending register. Its bit i reads 1 exactly when source i is active and enabled. Word indices 5 to 7 read zero, and writes to them change nothing.
- R4: Word index 4 selects the capture mode, with 1 meaning edge and 0 meaning level. An edge source is active from the cycle after a rising edge is sampled and stays active after the line falls. Clearing its mode bit discards the latched edge.
- R5: Writing index 1 clears the latched edge of each edge source whose data bit is 1. Zero data bits and level sources are unaffected. A rising edge sampled in the same cycle as the clear wins.
- R6: A level source is active, in the same cycle, whenever its line is high.
- R7: Word index 2 is the routing register. `irq_o` is the registered OR of the pending bits whose routing bit is 0, and `fiq_o` is the registered OR of those whose routing bit is 1. Both change one clock after the pending bits change.
- R8: Word index 3, bit 0, is the wake qualifier. When it is 1, a wake needs at least one pending bit. When it is 0, any active source will do, masked or not. The other bits of index 3 read zero.
- R9: `wake_o` rises two clocks after `idle_i` is first sampled high with a qualifying source active. It is high only in `ST_WAKE`.
- R10: Once raised, `wake_o` stays high while `idle_i` stays high, even if the sources go quiet. It falls one clock after `idle_i` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| src_i | input | NSRC (32) | Raw interrupt source lines |
| idle_i | input | 1 | Processor is in idle mode |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Request to leave idle mode |

## Verification
The bench aims at the following corner cases, each paired with the failure it would expose:

- **Edge then clear.** An edge source pulses and is then cleared by a write of one. A design that does not keep the edge would lose the interrupt once the line falls. A design that ignores the clear would keep requesting forever.
- **Clear on the same cycle as a new edge.** A design with the wrong priority would drop a real second interrupt.
- **Masked source in idle mode.** With the qualifier bit clear, a masked source must wake the processor. With the bit set, it must not. A design that swaps the qualifier meaning would fail one of the two runs.
- **Routing changes.** These catch swapped or unregistered `irq_o` and `fiq_o` outputs.
- **Unmapped indices.** Writes there catch address decoding that aliases onto a real register.

// File: rtl/ic_pkg.sv
package ic_pkg;

    // Register word indices; behaviour depends on these positions
    typedef enum logic [2:0] {
        SEL_MASK  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_STEER = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_EMODE = 3'd4
    } reg_sel_e;

    // Idle-wake state machine
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } wake_st_e;

endpackage

// File: rtl/ic_src_capture.sv
module ic_src_capture #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] emode_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] active_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic src_q;
        logic sticky_q;
        logic rise;

        assign rise = src_i[g] && !src_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q    <= 1'b0;
                sticky_q <= 1'b0;
            end else begin
                src_q <= src_i[g];
                if (!emode_i[g])
                    sticky_q <= 1'b0;
                else if (rise)
                    sticky_q <= 1'b1;   // new edge beats a clear (R5)
                else if (clr_i[g])
                    sticky_q <= 1'b0;
            end
        end

        assign active_o[g] = emode_i[g] ? sticky_q : src_i[g];

        a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (emode_i[g] && sticky_q && !clr_i[g]) |=> sticky_q);

        a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (emode_i[g] && clr_i[g] && !rise) |=> !sticky_q);
    end

endmodule

// File: rtl/ic_regs.sv
module ic_regs
    import ic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NSRC-1:0] pend_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] steer_o,
    output logic [NSRC-1:0] emode_o,
    output logic            ctrl_o,
    output logic [NSRC-1:0] clr_o,
    output logic [DW-1:0]   rdata_o
);

    logic wr_mask, wr_steer, wr_ctrl, wr_emode, wr_pend;

    assign wr_mask  = wr_i && (addr_i == AW'(SEL_MASK));
    assign wr_pend  = wr_i && (addr_i == AW'(SEL_PEND));
    assign wr_steer = wr_i && (addr_i == AW'(SEL_STEER));
    assign wr_ctrl  = wr_i && (addr_i == AW'(SEL_CTRL));
    assign wr_emode = wr_i && (addr_i == AW'(SEL_EMODE));

    assign clr_o = wr_pend ? wdata_i[NSRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o  <= '0;
            steer_o <= '0;
            emode_o <= '0;
            ctrl_o  <= 1'b0;
        end else begin
            if (wr_mask)  mask_o  <= wdata_i[NSRC-1:0];
            if (wr_steer) steer_o <= wdata_i[NSRC-1:0];
            if (wr_emode) emode_o <= wdata_i[NSRC-1:0];
            if (wr_ctrl)  ctrl_o  <= wdata_i[0];
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            AW'(SEL_MASK):  rdata_o[NSRC-1:0] = mask_o;
            AW'(SEL_PEND):  rdata_o[NSRC-1:0] = pend_i;
            AW'(SEL_STEER): rdata_o[NSRC-1:0] = steer_o;
            AW'(SEL_CTRL):  rdata_o[0]        = ctrl_o;
            AW'(SEL_EMODE): rdata_o[NSRC-1:0] = emode_o;
            default:        rdata_o           = '0;
        endcase
    end

    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_o == $past(wdata_i[NSRC-1:0])));

    a_r3_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i > AW'(SEL_EMODE)) |=>
            ($stable(mask_o) && $stable(steer_o) && $stable(emode_o) && $stable(ctrl_o)));

endmodule

// File: rtl/ic_wake_fsm.sv
module ic_wake_fsm
    import ic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic qualify_i,
    output logic wake_o
);

    wake_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (idle_i) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (!idle_i)        state_d = ST_RUN;
                else if (qualify_i) state_d = ST_WAKE;
            end
            ST_WAKE:  if (!idle_i) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        wake_o = (state_q == ST_WAKE);
    end

    a_r9_wake_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(idle_i));

    a_r10_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && idle_i) |=> wake_o);

endmodule

// File: rtl/ic_irq_fiq_ctl.sv
module ic_irq_fiq_ctl
    import ic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_i,
    input  logic            idle_i,
    output logic            irq_o,
    output logic            fiq_o,
    output logic            wake_o
);

    logic [NSRC-1:0] mask_q, steer_q, emode_q, clr_edge, active, pend;
    logic            ctrl_q, qualify;

    ic_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .pend_i  (pend),
        .mask_o  (mask_q),
        .steer_o (steer_q),
        .emode_o (emode_q),
        .ctrl_o  (ctrl_q),
        .clr_o   (clr_edge),
        .rdata_o (bus_rdata)
    );

    ic_src_capture #(.NSRC(NSRC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .emode_i  (emode_q),
        .clr_i    (clr_edge),
        .active_o (active)
    );

    assign pend    = active & mask_q;
    assign qualify = ctrl_q ? (|pend) : (|active);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(pend & ~steer_q);
            fiq_o <= |(pend & steer_q);
        end
    end

    ic_wake_fsm u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_i    (idle_i),
        .qualify_i (qualify),
        .wake_o    (wake_o)
    );

    a_r7_fiq_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(steer_q != '0));

    a_r7_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (!irq_o && !fiq_o));

endmodule

// File: tb/sim_ic_irq_fiq_ctl.sv
`timescale 1ns/1ps
module sim_ic_irq_fiq_ctl;

    localparam int NSRC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src = '0;
    logic        idle = 1'b0;
    logic        irq, fiq, wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_mask, m_steer, m_emode, m_sticky, m_srcq;
    logic        m_ctrl, m_irq, m_fiq;
    int          m_st;   // 0 run, 1 sleep, 2 wake

    always #2 clk = ~clk;

    ic_irq_fiq_ctl #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src),
        .idle_i(idle), .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    function automatic logic [31:0] f_active();
        return (m_emode & m_sticky) | (~m_emode & src);
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a);
        case (a)
            3'd0: return m_mask;
            3'd1: return f_active() & m_mask;
            3'd2: return m_steer;
            3'd3: return {31'b0, m_ctrl};
            3'd4: return m_emode;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string f_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic model_reset();
        m_mask = '0; m_steer = '0; m_emode = '0; m_sticky = '0; m_srcq = '0;
        m_ctrl = 1'b0; m_irq = 1'b0; m_fiq = 1'b0; m_st = 0;
    endtask

    task automatic model_step();
        logic [31:0] act, pend, clr;
        logic        qual;
        act  = f_active();
        pend = act & m_mask;
        qual = m_ctrl ? (pend != 0) : (act != 0);
        clr  = (bus_wr && bus_addr == 3'd1) ? bus_wdata : 32'h0;
        m_irq = |(pend & ~m_steer);
        m_fiq = |(pend & m_steer);
        case (m_st)
            0: if (idle) m_st = 1;
            1: if (!idle) m_st = 0; else if (qual) m_st = 2;
            default: if (!idle) m_st = 0;
        endcase
        m_sticky = m_emode & (((m_sticky & ~clr)) | (src & ~m_srcq));
        m_srcq = src;
        if (bus_wr) begin
            case (bus_addr)
                3'd0: m_mask  = bus_wdata;
                3'd2: m_steer = bus_wdata;
                3'd3: m_ctrl  = bus_wdata[0];
                3'd4: m_emode = bus_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, compare, then advance the model.
    task automatic cyc(input logic [2:0] a, input logic w, input logic [31:0] d,
                       input logic [31:0] s, input logic idl, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; src = s; idle = idl;
        #1;
        chk((tag == "") ? f_tag(a) : tag, "rdata", bus_rdata, f_read(a));
        chk((tag == "") ? "R7" : tag, "irq", {31'b0, irq}, {31'b0, m_irq});
        chk((tag == "") ? "R7" : tag, "fiq", {31'b0, fiq}, {31'b0, m_fiq});
        chk((tag == "") ? "R9" : tag, "wake", {31'b0, wake}, {31'b0, (m_st == 2)});
        @(posedge clk);
        model_step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s_r;
        logic        i_r;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register and output
        for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 32'h0, 32'h0, 1'b0, "R1");

        // R2: enable register write and read-back
        cyc(3'd0, 1'b1, 32'h0000_00FF, 32'h0, 1'b0, "R2");
        cyc(3'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R2");
        // R6: level sources show at once; R3: masked bit 8 stays out of pending
        cyc(3'd1, 1'b0, 32'h0, 32'h0000_0105, 1'b0, "R6");
        cyc(3'd1, 1'b0, 32'h0, 32'h0000_0105, 1'b0, "R3");
        // R7: route bit 2 to the fast line
        cyc(3'd2, 1'b1, 32'h0000_0004, 32'h0000_0105, 1'b0, "R7");
        cyc(3'd1, 1'b0, 32'h0, 32'h0000_0105, 1'b0, "R7");
        cyc(3'd1, 1'b0, 32'h0, 32'h0000_0004, 1'b0, "R7");
        cyc(3'd1, 1'b0, 32'h0, 32'h0, 1'b0, "R7");
        // R4: bit 1 in edge mode, pulse and hold
        cyc(3'd4, 1'b1, 32'h0000_0002, 32'h0, 1'b0, "R4");
        cyc(3'd1, 1'b0, 32'h0, 32'h0000_0002, 1'b0, "R4");
        for (int k = 0; k < 3; k++) cyc(3'd1, 1'b0, 32'h0, 32'h0, 1'b0, "R4");
        // R5: zero-data write leaves the edge, one-data write clears it
        cyc(3'd1, 1'b1, 32'h0000_0001, 32'h0000_0001, 1'b0, "R5");
        cyc(3'd1, 1'b1, 32'h0000_0002, 32'h0000_0001, 1'b0, "R5");
        cyc(3'd1, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        // R5: new edge on the same cycle as a clear survives
        cyc(3'd1, 1'b0, 32'h0, 32'h0000_0002, 1'b0, "R5");
        cyc(3'd1, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        cyc(3'd1, 1'b1, 32'h0000_0002, 32'h0000_0002, 1'b0, "R5");
        cyc(3'd1, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        cyc(3'd1, 1'b1, 32'h0000_0002, 32'h0, 1'b0, "R5");
        // R3: unmapped index writes are inert and read zero
        cyc(3'd5, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, "R3");
        cyc(3'd7, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, "R3");
        for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 32'h0, 32'h0, 1'b0, "R3");

        // R8: qualifier clear, masked source wakes the idle processor
        cyc(3'd3, 1'b1, 32'h0, 32'h0000_0100, 1'b0, "R8");
        for (int k = 0; k < 4; k++) cyc(3'd3, 1'b0, 32'h0, 32'h0000_0100, 1'b1, "R8");
        // R10: wake held with sources quiet, then drops after idle ends
        for (int k = 0; k < 3; k++) cyc(3'd3, 1'b0, 32'h0, 32'h0, 1'b1, "R10");
        for (int k = 0; k < 2; k++) cyc(3'd3, 1'b0, 32'h0, 32'h0, 1'b0, "R10");
        // R8: qualifier set, masked source must not wake; enabled one does (R9)
        cyc(3'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_0100, 1'b0, "R8");
        for (int k = 0; k < 4; k++) cyc(3'd3, 1'b0, 32'h0, 32'h0000_0100, 1'b1, "R8");
        for (int k = 0; k < 3; k++) cyc(3'd3, 1'b0, 32'h0, 32'h0000_0101, 1'b1, "R9");
        cyc(3'd3, 1'b0, 32'h0, 32'h0, 1'b0, "R10");

        // constrained random phase
        s_r = '0; i_r = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            logic [2:0]  a;
            logic        w;
            logic [31:0] d;
            a = 3'($urandom % 8);
            w = ($urandom % 3) == 0;
            d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            if ($urandom % 4 == 0) s_r = $urandom & $urandom & $urandom;
            if ($urandom % 16 == 0) i_r = ~i_r;
            cyc(a, w, d, s_r, i_r, "");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule